// File: doc/BRIEF.md
# Write-Once System Option and Reset Request Registers

This block holds the system option byte of a small microcontroller. The CPU can write that byte once after each reset. After the first write the value is locked, so stray code cannot change the watchdog, stop and debug-pin settings later. The block has a second port for a background-debug host, which the CPU does not share. Through that port the host can force a system reset. The block also gates the low-voltage comparator into a reset request, according to the detect enables and stop mode.

The block reports one reset cause. A status bit is 1 when the last reset came from power-on or a low-voltage trip, and 0 when it came from a debug-forced reset. Each reset request appears on `rst_req_o` for one clock. In the cycle after the pulse, the block returns all of its option state to the reset values. Only the reset-cause bit survives, because it is cleared by power-on alone.

Top module: `sysopt_regs`

## Requirements
- R1: While `por_n` is low, the option byte `opt_o` is 0xD3 and `rst_req_o` is 0. After `por_n` is released, a CPU read at address 0 returns 0xD3 and a read at address 2 returns 0x01.
- R2: The first CPU write to address 0 after a reset loads `cpu_wdata & 0xF3`. The new value is seen on `opt_o` and on a read the clock after the write. Bits 3 and 2 always read 0.
- R3: Once the option byte is written, every later CPU write to address 0 leaves it unchanged until the next reset. This holds even when the later write carries the same value.
- R4: A CPU write of any data to address 1 (force-reset) never raises `rst_req_o`. A CPU read of address 1 always returns 0x00.
- R5: A debug write to address 1 with `dbg_bit` = 1 drives `rst_req_o` high for exactly one clock, starting the clock after the write. A debug write with `dbg_bit` = 0, or to any other address, has no effect.
- R6: In the clock after `rst_req_o` is high, `opt_o` is back to 0xD3 and the write lock is clear, so the next CPU write is accepted.
- R7: A low-voltage reset request is raised the clock after `lvd_en`, `lvd_rst_en` and `lv_below` are all 1. If any of the three is 0, no request is raised.
- R8: While `stop_mode` is 1, the low-voltage request is suppressed unless `lvd_stop_en` is 1.
- R9: The reset-cause bit (bit 0 at address 2) reads 1 after power-on or after a low-voltage reset, and 0 after a debug-forced reset.
- R10: A CPU write to address 0 and a debug force-reset can land in the same clock. In that case the write is applied under the lock rule and shows on `opt_o` for one clock while `rst_req_o` is high. The reset then restores 0xD3.
- R11: CPU writes made in the clock where `rst_req_o` is high are discarded and do not take the lock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| cpu_we | input | 1 | CPU write strobe |
| cpu_addr | input | 2 | CPU register address (0 options, 1 force-reset, 2 status) |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data for `cpu_addr` (combinational) |
| dbg_we | input | 1 | Debug-port write strobe |
| dbg_addr | input | 2 | Debug-port register address |
| dbg_bit | input | 1 | Debug-port write data bit 0 |
| lv_below | input | 1 | Comparator: supply below trip point |
| lvd_en | input | 1 | Low-voltage detect enable |
| lvd_rst_en | input | 1 | Low-voltage detect reset enable |
| lvd_stop_en | input | 1 | Keep low-voltage detect active in stop mode |
| stop_mode | input | 1 | Device is in stop mode |
| opt_o | output | 8 | Current option byte |
| rst_req_o | output | 1 | One-clock system reset request |

## Verification
A CPU write to the option byte can land in the same clock as a debug force-reset. The bench provokes this by driving both strobes at one negative edge. It then expects the written value and a high `rst_req_o` one clock later, and the value 0xD3 with the lock clear one clock after that. A CPU write issued during the reset-pulse clock is also judged. It must leave no trace after the reset, and a write made after the reset must still be accepted.

// File: rtl/sysopt_pkg.sv
package sysopt_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_OPT = 2'd0;
    localparam logic [ADDR_W-1:0] A_FRC = 2'd1;
    localparam logic [ADDR_W-1:0] A_STS = 2'd2;

    // bit7 watchdog on, bit6 long timeout, bit5 stop off, bit4 spare, bit1 debug pin on, bit0 spare
    localparam logic [DATA_W-1:0] OPT_RST  = 8'hD3;
    localparam logic [DATA_W-1:0] OPT_MASK = 8'hF3;

    typedef struct packed {
        logic [DATA_W-1:0] val;
        logic              lock;
    } opt_st_t;

    typedef struct packed {
        logic req;
        logic req_lvd;
        logic src_flag;
    } rst_st_t;
endpackage

// File: rtl/opt_lock.sv
module opt_lock
    import sysopt_pkg::*;
(
    input  logic              clk,
    input  logic              por_n,
    input  logic              sync_clr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] val,
    output logic              locked
);
    opt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sync_clr) begin
            st_d.val  = OPT_RST;
            st_d.lock = 1'b0;
        end else if (wr_en && !st_q.lock) begin
            st_d.val  = wdata & OPT_MASK;
            st_d.lock = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q.val  <= OPT_RST;
            st_q.lock <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign val    = st_q.val;
    assign locked = st_q.lock;
endmodule

// File: rtl/lvd_gate.sv
module lvd_gate (
    input  logic lv_below,
    input  logic lvd_en,
    input  logic lvd_rst_en,
    input  logic lvd_stop_en,
    input  logic stop_mode,
    output logic trip
);
    logic active;

    always_comb begin
        active = lvd_en && (!stop_mode || lvd_stop_en);
        trip   = active && lvd_rst_en && lv_below;
    end
endmodule

// File: rtl/rst_ctrl.sv
module rst_ctrl
    import sysopt_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic force_hit,
    input  logic lvd_trip,
    output logic req,
    output logic src_flag
);
    rst_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.req) begin
            // reset is being applied this clock: record its cause, drop the pulse
            st_d.req      = 1'b0;
            st_d.req_lvd  = 1'b0;
            st_d.src_flag = st_q.req_lvd;
        end else begin
            st_d.req     = force_hit || lvd_trip;
            st_d.req_lvd = lvd_trip;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q.req      <= 1'b0;
            st_q.req_lvd  <= 1'b0;
            st_q.src_flag <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign req      = st_q.req;
    assign src_flag = st_q.src_flag;
endmodule

// File: rtl/sysopt_regs.sv
module sysopt_regs
    import sysopt_pkg::*;
(
    input  logic              clk,
    input  logic              por_n,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              dbg_we,
    input  logic [ADDR_W-1:0] dbg_addr,
    input  logic              dbg_bit,
    input  logic              lv_below,
    input  logic              lvd_en,
    input  logic              lvd_rst_en,
    input  logic              lvd_stop_en,
    input  logic              stop_mode,
    output logic [DATA_W-1:0] opt_o,
    output logic              rst_req_o
);
    logic opt_wr;
    logic opt_locked;
    logic force_hit;
    logic lvd_trip;
    logic src_flag;

    always_comb begin
        opt_wr    = cpu_we && (cpu_addr == A_OPT) && !rst_req_o;
        force_hit = dbg_we && (dbg_addr == A_FRC) && dbg_bit;
    end

    opt_lock i_opt (
        .clk      (clk),
        .por_n    (por_n),
        .sync_clr (rst_req_o),
        .wr_en    (opt_wr),
        .wdata    (cpu_wdata),
        .val      (opt_o),
        .locked   (opt_locked)
    );

    lvd_gate i_lvd (
        .lv_below    (lv_below),
        .lvd_en      (lvd_en),
        .lvd_rst_en  (lvd_rst_en),
        .lvd_stop_en (lvd_stop_en),
        .stop_mode   (stop_mode),
        .trip        (lvd_trip)
    );

    rst_ctrl i_rst (
        .clk       (clk),
        .por_n     (por_n),
        .force_hit (force_hit),
        .lvd_trip  (lvd_trip),
        .req       (rst_req_o),
        .src_flag  (src_flag)
    );

    always_comb begin
        case (cpu_addr)
            A_OPT:   cpu_rdata = opt_o;
            A_STS:   cpu_rdata = {{(DATA_W-1){1'b0}}, src_flag};
            default: cpu_rdata = '0;
        endcase
    end
endmodule

// File: rtl/sysopt_regs_chk.sv
module sysopt_regs_chk
    import sysopt_pkg::*;
(
    input logic              clk,
    input logic              por_n,
    input logic              cpu_we,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic [DATA_W-1:0] cpu_wdata,
    input logic [DATA_W-1:0] cpu_rdata,
    input logic              dbg_we,
    input logic [ADDR_W-1:0] dbg_addr,
    input logic              dbg_bit,
    input logic              lv_below,
    input logic              lvd_en,
    input logic              lvd_rst_en,
    input logic              lvd_stop_en,
    input logic              stop_mode,
    input logic [DATA_W-1:0] opt_o,
    input logic              rst_req_o,
    input logic              opt_locked
);
    logic dbg_force;
    assign dbg_force = dbg_we && (dbg_addr == A_FRC) && dbg_bit;

    p_unimpl_zero_r2: assert property (@(posedge clk) disable iff (!por_n)
        opt_o[3:2] == 2'b00);

    p_first_write_r2: assert property (@(posedge clk) disable iff (!por_n)
        (cpu_we && cpu_addr == A_OPT && !opt_locked && !rst_req_o)
        |=> (opt_o == ($past(cpu_wdata) & OPT_MASK)));

    p_locked_hold_r3: assert property (@(posedge clk) disable iff (!por_n)
        (opt_locked && !rst_req_o) |=> $stable(opt_o));

    p_force_reads_zero_r4: assert property (@(posedge clk) disable iff (!por_n)
        (cpu_addr == A_FRC) |-> (cpu_rdata == '0));

    p_dbg_request_r5: assert property (@(posedge clk) disable iff (!por_n)
        (dbg_force && !rst_req_o) |=> rst_req_o);

    p_one_clock_pulse_r5: assert property (@(posedge clk) disable iff (!por_n)
        rst_req_o |=> !rst_req_o);

    p_reset_restores_r6: assert property (@(posedge clk) disable iff (!por_n)
        rst_req_o |=> (opt_o == OPT_RST && !opt_locked));

    p_lvd_request_r7: assert property (@(posedge clk) disable iff (!por_n)
        (lvd_en && lvd_rst_en && lv_below && !stop_mode && !rst_req_o) |=> rst_req_o);

    p_stop_gate_r8: assert property (@(posedge clk) disable iff (!por_n)
        (stop_mode && !lvd_stop_en && !dbg_force && !rst_req_o) |=> !rst_req_o);
endmodule

bind sysopt_regs sysopt_regs_chk i_chk (
    .clk         (clk),
    .por_n       (por_n),
    .cpu_we      (cpu_we),
    .cpu_addr    (cpu_addr),
    .cpu_wdata   (cpu_wdata),
    .cpu_rdata   (cpu_rdata),
    .dbg_we      (dbg_we),
    .dbg_addr    (dbg_addr),
    .dbg_bit     (dbg_bit),
    .lv_below    (lv_below),
    .lvd_en      (lvd_en),
    .lvd_rst_en  (lvd_rst_en),
    .lvd_stop_en (lvd_stop_en),
    .stop_mode   (stop_mode),
    .opt_o       (opt_o),
    .rst_req_o   (rst_req_o),
    .opt_locked  (opt_locked)
);

// File: tb/test_sysopt_regs.sv
`timescale 1ns/1ps
module test_sysopt_regs;
    logic       clk = 1'b0;
    logic       por_n;
    logic       cpu_we;
    logic [1:0] cpu_addr;
    logic [7:0] cpu_wdata;
    logic [7:0] cpu_rdata;
    logic       dbg_we;
    logic [1:0] dbg_addr;
    logic       dbg_bit;
    logic       lv_below, lvd_en, lvd_rst_en, lvd_stop_en, stop_mode;
    logic [7:0] opt_o;
    logic       rst_req_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    sysopt_regs i_sysopt_regs (
        .clk(clk), .por_n(por_n),
        .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .dbg_we(dbg_we), .dbg_addr(dbg_addr), .dbg_bit(dbg_bit),
        .lv_below(lv_below), .lvd_en(lvd_en), .lvd_rst_en(lvd_rst_en),
        .lvd_stop_en(lvd_stop_en), .stop_mode(stop_mode),
        .opt_o(opt_o), .rst_req_o(rst_req_o)
    );

    // [5] lvd_en [4] lvd_rst_en [3] lvd_stop_en [2] stop_mode [1] lv_below [0] expected request
    localparam logic [5:0] LVD_VEC [8] = '{
        6'b110011, 6'b110000, 6'b010010, 6'b100010,
        6'b110110, 6'b111111, 6'b111011, 6'b000010
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        cpu_we = 0; cpu_wdata = 0; dbg_we = 0; dbg_addr = 0; dbg_bit = 0;
        lv_below = 0; lvd_en = 0; lvd_rst_en = 0; lvd_stop_en = 0; stop_mode = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        cpu_addr = a;
        #0.5;
        v = cpu_rdata;
    endtask

    task automatic cpu_wr(input logic [1:0] a, input logic [7:0] d);
        cpu_we = 1; cpu_addr = a; cpu_wdata = d;
        step();
        cpu_we = 0;
    endtask

    // debug force; returns after the pulse clock and the reset clock have been checked
    task automatic force_reset(input string tag);
        dbg_we = 1; dbg_addr = 2'd1; dbg_bit = 1;
        step();
        idle();
        chk({tag, " pulse high"}, {7'b0, rst_req_o}, 8'h01);
        step();
        chk({tag, " pulse ends"}, {7'b0, rst_req_o}, 8'h00);
        chk({tag, " opt restored"}, opt_o, 8'hD3);
    endtask

    initial begin
        #1000000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        por_n = 0; cpu_addr = 0; idle();
        repeat (3) @(negedge clk);
        chk("R1 opt during reset", opt_o, 8'hD3);
        chk("R1 req during reset", {7'b0, rst_req_o}, 8'h00);
        por_n = 1;
        step();
        rd(2'd0, v); chk("R1 read opt", v, 8'hD3);
        rd(2'd2, v); chk("R1 R9 status after power-on", v, 8'h01);

        // R4: cpu cannot force a reset
        cpu_wr(2'd1, 8'hFF);
        chk("R4 cpu write force no req", {7'b0, rst_req_o}, 8'h00);
        rd(2'd1, v); chk("R4 force reads zero", v, 8'h00);

        // R2 first write, R3 lock
        cpu_wr(2'd0, 8'h2C);
        chk("R2 first write masked", opt_o, 8'h20);
        rd(2'd0, v); chk("R2 read back", v, 8'h20);
        cpu_wr(2'd0, 8'hFF);
        chk("R3 second write ignored", opt_o, 8'h20);
        cpu_wr(2'd0, 8'h20);
        cpu_wr(2'd0, 8'h00);
        chk("R3 write after same-value ignored", opt_o, 8'h20);

        // R5 ignored debug writes
        dbg_we = 1; dbg_addr = 2'd1; dbg_bit = 0; step(); idle();
        chk("R5 dbg bit0=0 no req", {7'b0, rst_req_o}, 8'h00);
        dbg_we = 1; dbg_addr = 2'd0; dbg_bit = 1; step(); idle();
        chk("R5 dbg other addr no req", {7'b0, rst_req_o}, 8'h00);
        chk("R5 dbg other addr opt kept", opt_o, 8'h20);

        force_reset("R5 R6 force");
        rd(2'd2, v); chk("R9 status after force", v, 8'h00);
        cpu_wr(2'd0, 8'h41);
        chk("R6 lock cleared by reset", opt_o, 8'h41);

        // R11 write during pulse clock discarded
        dbg_we = 1; dbg_addr = 2'd1; dbg_bit = 1;
        step(); idle();
        chk("R11 pulse high", {7'b0, rst_req_o}, 8'h01);
        cpu_wr(2'd0, 8'h00);
        chk("R11 write in pulse discarded", opt_o, 8'hD3);
        cpu_wr(2'd0, 8'h80);
        chk("R11 lock not taken", opt_o, 8'h80);

        // R10 same-cycle cpu write and debug force
        force_reset("R10 prep");
        cpu_we = 1; cpu_addr = 2'd0; cpu_wdata = 8'h1E;
        dbg_we = 1; dbg_addr = 2'd1; dbg_bit = 1;
        step(); idle();
        chk("R10 write visible", opt_o, 8'h12);
        chk("R10 req high", {7'b0, rst_req_o}, 8'h01);
        step();
        chk("R10 opt restored", opt_o, 8'hD3);
        chk("R10 req low", {7'b0, rst_req_o}, 8'h00);
        rd(2'd2, v); chk("R10 R9 status force", v, 8'h00);

        // R7 R8 R9 low-voltage table
        foreach (LVD_VEC[i]) begin
            lvd_en = LVD_VEC[i][5]; lvd_rst_en = LVD_VEC[i][4];
            lvd_stop_en = LVD_VEC[i][3]; stop_mode = LVD_VEC[i][2];
            lv_below = LVD_VEC[i][1];
            step(); idle();
            chk($sformatf("R7 R8 lvd vector %0d", i), {7'b0, rst_req_o}, {7'b0, LVD_VEC[i][0]});
            if (LVD_VEC[i][0]) begin
                step();
                chk($sformatf("R7 lvd reset done %0d", i), {7'b0, rst_req_o}, 8'h00);
                rd(2'd2, v); chk($sformatf("R9 status after lvd %0d", i), v, 8'h01);
            end
        end

        force_reset("R9 final force");
        rd(2'd2, v); chk("R9 status cleared again", v, 8'h00);
        por_n = 0; step(); por_n = 1; step();
        rd(2'd2, v); chk("R1 R9 status after second power-on", v, 8'h01);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule